// File: doc/BRIEF.md
# Eight-Point Fixed-Point Inverse DCT Datapath

This block evaluates a one-dimensional eight-point inverse discrete cosine transform on eight signed 16-bit coefficients per cycle. It uses integer constants scaled by 2^13. It splits the work into an even butterfly (coefficients 0, 2, 4, 6) and an odd butterfly (coefficients 1, 3, 5, 7), and merges them into eight sums. Each sum is rounded, arithmetically shifted right and clamped to 16 bits. A pass flag that travels with each input vector picks the shift, so one instance can serve both the column pass and the row pass of a two-dimensional transform. Transposition, dequantization and the sample level shift belong to surrounding logic.

The datapath is a two-stage pipeline that accepts a new vector every cycle. The first stage registers the even and odd partial results. The second stage registers the rounded, clamped outputs.

Top module: `idct8_core`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_vec` is all zeros.
- R2: `out_valid` equals `in_valid` delayed by exactly two clock edges, and a new vector may be accepted on every cycle.
- R3: Even part, with inputs x0..x7: a = (x0+x4)·8192 and b = (x0−x4)·8192. t2 = x2·4433 + x6·(4433−15137) and t3 = x2·(4433+6270) + x6·4433. The terms are e0 = a+t3, e1 = b+t2, e2 = b−t2 and e3 = a−t3. An input whose only nonzero lane is 0 gives eight equal outputs. An all-zero input gives all-zero outputs.
- R4: Odd part. u = x7+x3 and w = x5+x1. zu = u·(9633−16069) + w·9633 and zv = u·9633 + w·(9633−3196). The terms are o0 = x7·(2446−7373) − x1·7373 + zu, o1 = x5·(16819−20995) − x3·20995 + zv, o2 = −x5·20995 + x3·(25172−20995) + zu and o3 = −x7·7373 + x1·(12299−7373) + zv. Output j is ej + o(3−j) and output 7−j is ej − o(3−j), for j = 0..3.
- R5: Every sum has 2^(n−1) added and is then shifted right arithmetically (floor) by n. n is 11 when the pass flag is 0 and 18 when it is 1.
- R6: After the shift, each result is clamped to the range −32768..32767.
- R7: The pass flag is taken together with its vector, so vectors of different passes may alternate from cycle to cycle without affecting one another.
- R8: When `out_valid` is 0, `out_vec` keeps the value it had in the previous cycle.
- R9: Lane k of `in_vec` and `out_vec` occupies bits [16k+15:16k]. Products are 16×16 into 32 bits, and the 32-bit sums are never clamped before the final clamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector valid |
| in_pass | input | 1 | Shift select: 0 gives shift 11, 1 gives shift 18 |
| in_vec | input | 128 | Eight signed 16-bit coefficients, lane k at [16k+15:16k] |
| out_valid | output | 1 | Output vector valid |
| out_vec | output | 128 | Eight signed 16-bit results, lane k at [16k+15:16k] |

## Verification
A vector presented before rising edge E appears on `out_vec` with `out_valid` high after edge E+1. The bench drives on falling edges and samples on falling edges. It keeps a two-entry shift of `in_valid` taken at rising edges to predict `out_valid` in each cycle. Expected vectors are queued in drive order and popped only when `out_valid` is seen, so streams with gaps and alternating passes line up. In cycles without a result, the bench compares `out_vec` with its previous value.

// File: rtl/idct8_pkg.sv
package idct8_pkg;

    localparam int SAMP_W    = 16;
    localparam int ACC_W     = 32;
    localparam int FRAC_BITS = 13;
    localparam int LANES     = 8;
    localparam int SHIFT_COL = 11;
    localparam int SHIFT_ROW = 18;

    // cosine-derived weights, value * 2^13 rounded
    localparam int K0298 = 2446;
    localparam int K0390 = 3196;
    localparam int K0541 = 4433;
    localparam int K0765 = 6270;
    localparam int K0900 = 7373;
    localparam int K1176 = 9633;
    localparam int K1501 = 12299;
    localparam int K1848 = 15137;
    localparam int K1962 = 16069;
    localparam int K2053 = 16819;
    localparam int K2563 = 20995;
    localparam int K3073 = 25172;

endpackage

// File: rtl/idct8_even.sv
module idct8_even
    import idct8_pkg::*;
#(
    parameter int SW = SAMP_W,
    parameter int AW = ACC_W,
    parameter int FB = FRAC_BITS
) (
    input  logic signed [SW-1:0] x0,
    input  logic signed [SW-1:0] x2,
    input  logic signed [SW-1:0] x4,
    input  logic signed [SW-1:0] x6,
    output logic signed [AW-1:0] e0,
    output logic signed [AW-1:0] e1,
    output logic signed [AW-1:0] e2,
    output logic signed [AW-1:0] e3
);
    localparam logic signed [AW-1:0] C_T2P = AW'(K0541);
    localparam logic signed [AW-1:0] C_T2Q = AW'(K0541 - K1848);
    localparam logic signed [AW-1:0] C_T3P = AW'(K0541 + K0765);
    localparam logic signed [AW-1:0] C_T3Q = AW'(K0541);

    logic signed [AW-1:0] w0, w2, w4, w6;
    logic signed [AW-1:0] sum_a, dif_b, rot2, rot3;

    always_comb begin
        w0    = AW'(x0);
        w2    = AW'(x2);
        w4    = AW'(x4);
        w6    = AW'(x6);
        sum_a = (w0 + w4) <<< FB;
        dif_b = (w0 - w4) <<< FB;
        rot2  = w2 * C_T2P + w6 * C_T2Q;
        rot3  = w2 * C_T3P + w6 * C_T3Q;
        e0    = sum_a + rot3;
        e1    = dif_b + rot2;
        e2    = dif_b - rot2;
        e3    = sum_a - rot3;
    end

endmodule

// File: rtl/idct8_odd.sv
module idct8_odd
    import idct8_pkg::*;
#(
    parameter int SW = SAMP_W,
    parameter int AW = ACC_W
) (
    input  logic signed [SW-1:0] x1,
    input  logic signed [SW-1:0] x3,
    input  logic signed [SW-1:0] x5,
    input  logic signed [SW-1:0] x7,
    output logic signed [AW-1:0] o0,
    output logic signed [AW-1:0] o1,
    output logic signed [AW-1:0] o2,
    output logic signed [AW-1:0] o3
);
    localparam logic signed [AW-1:0] C_ZUU = AW'(K1176 - K1962);
    localparam logic signed [AW-1:0] C_MID = AW'(K1176);
    localparam logic signed [AW-1:0] C_ZVW = AW'(K1176 - K0390);
    localparam logic signed [AW-1:0] C_P7A = AW'(K0298 - K0900);
    localparam logic signed [AW-1:0] C_NEG9 = AW'(-K0900);
    localparam logic signed [AW-1:0] C_P5B = AW'(K2053 - K2563);
    localparam logic signed [AW-1:0] C_NEG25 = AW'(-K2563);
    localparam logic signed [AW-1:0] C_P3C = AW'(K3073 - K2563);
    localparam logic signed [AW-1:0] C_P1D = AW'(K1501 - K0900);

    logic signed [AW-1:0] w1, w3, w5, w7;
    logic signed [AW-1:0] pair_u, pair_w, zu, zv;

    always_comb begin
        w1     = AW'(x1);
        w3     = AW'(x3);
        w5     = AW'(x5);
        w7     = AW'(x7);
        pair_u = w7 + w3;
        pair_w = w5 + w1;
        zu     = pair_u * C_ZUU + pair_w * C_MID;
        zv     = pair_u * C_MID + pair_w * C_ZVW;
        o0     = w7 * C_P7A + w1 * C_NEG9 + zu;
        o1     = w5 * C_P5B + w3 * C_NEG25 + zv;
        o2     = w5 * C_NEG25 + w3 * C_P3C + zu;
        o3     = w7 * C_NEG9 + w1 * C_P1D + zv;
    end

endmodule

// File: rtl/idct8_descale.sv
module idct8_descale
    import idct8_pkg::*;
#(
    parameter int SW  = SAMP_W,
    parameter int AW  = ACC_W,
    parameter int SH0 = SHIFT_COL,
    parameter int SH1 = SHIFT_ROW
) (
    input  logic                 sel,
    input  logic signed [AW-1:0] acc,
    output logic signed [SW-1:0] y
);
    localparam logic signed [AW-1:0] RND0 = AW'(1) <<< (SH0 - 1);
    localparam logic signed [AW-1:0] RND1 = AW'(1) <<< (SH1 - 1);
    localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (SW - 1)) - AW'(1);
    localparam logic signed [AW-1:0] MINV = -(AW'(1) <<< (SW - 1));

    logic signed [AW-1:0] shr0, shr1, shr_sel;

    always_comb begin
        shr0    = (acc + RND0) >>> SH0;
        shr1    = (acc + RND1) >>> SH1;
        shr_sel = sel ? shr1 : shr0;
        if (shr_sel > MAXV) begin
            y = MAXV[SW-1:0];
        end else if (shr_sel < MINV) begin
            y = MINV[SW-1:0];
        end else begin
            y = shr_sel[SW-1:0];
        end
    end

endmodule

// File: rtl/idct8_core.sv
module idct8_core
    import idct8_pkg::*;
#(
    parameter int SW  = SAMP_W,
    parameter int AW  = ACC_W,
    parameter int FB  = FRAC_BITS,
    parameter int SH0 = SHIFT_COL,
    parameter int SH1 = SHIFT_ROW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_pass,
    input  logic [LANES*SW-1:0]   in_vec,
    output logic                  out_valid,
    output logic [LANES*SW-1:0]   out_vec
);
    localparam int HALF = LANES / 2;

    typedef struct packed {
        logic                     v1;
        logic                     pass1;
        logic [HALF-1:0][AW-1:0]  ev;
        logic [HALF-1:0][AW-1:0]  od;
        logic                     v2;
        logic [LANES*SW-1:0]      res;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic signed [SW-1:0] lane_in   [LANES];
    logic signed [AW-1:0] ev_w      [HALF];
    logic signed [AW-1:0] od_w      [HALF];
    logic signed [AW-1:0] lane_sum  [LANES];
    logic signed [SW-1:0] lane_out  [LANES];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_unpack
            assign lane_in[g] = $signed(in_vec[g*SW +: SW]);
        end
    endgenerate

    idct8_even #(.SW(SW), .AW(AW), .FB(FB)) u_even (
        .x0 (lane_in[0]),
        .x2 (lane_in[2]),
        .x4 (lane_in[4]),
        .x6 (lane_in[6]),
        .e0 (ev_w[0]),
        .e1 (ev_w[1]),
        .e2 (ev_w[2]),
        .e3 (ev_w[3])
    );

    idct8_odd #(.SW(SW), .AW(AW)) u_odd (
        .x1 (lane_in[1]),
        .x3 (lane_in[3]),
        .x5 (lane_in[5]),
        .x7 (lane_in[7]),
        .o0 (od_w[0]),
        .o1 (od_w[1]),
        .o2 (od_w[2]),
        .o3 (od_w[3])
    );

    // output butterfly: lane j pairs even term j with odd term (HALF-1-j)
    generate
        for (g = 0; g < HALF; g++) begin : g_fly
            assign lane_sum[g] =
                $signed(pipe_q.ev[g]) + $signed(pipe_q.od[HALF-1-g]);
            assign lane_sum[LANES-1-g] =
                $signed(pipe_q.ev[g]) - $signed(pipe_q.od[HALF-1-g]);
        end
        for (g = 0; g < LANES; g++) begin : g_scale
            idct8_descale #(.SW(SW), .AW(AW), .SH0(SH0), .SH1(SH1)) u_ds (
                .sel (pipe_q.pass1),
                .acc (lane_sum[g]),
                .y   (lane_out[g])
            );
        end
    endgenerate

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d.v1 = in_valid;
        if (in_valid) begin
            pipe_d.pass1 = in_pass;
            for (int k = 0; k < HALF; k++) begin
                pipe_d.ev[k] = ev_w[k];
                pipe_d.od[k] = od_w[k];
            end
        end
        pipe_d.v2 = pipe_q.v1;
        if (pipe_q.v1) begin
            for (int k = 0; k < LANES; k++) begin
                pipe_d.res[k*SW +: SW] = lane_out[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.v2;
    assign out_vec   = pipe_q.res;

endmodule

// File: rtl/idct8_core_chk.sv
module idct8_core_chk #(
    parameter int SW    = 16,
    parameter int LANES = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [LANES*SW-1:0] in_vec,
    input logic                out_valid,
    input logic [LANES*SW-1:0] out_vec
);
    // edges seen since reset release, saturating
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (!out_valid && out_vec == '0)
                else $error("R1: outputs not cleared in reset");
        end
    end

    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)))
        else $error("R2: valid latency broken");

    assert_zero_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd2) && $past(in_valid, 2) && ($past(in_vec, 2) == '0))
        |-> (out_vec == '0))
        else $error("R3: zero input gave nonzero output");

    assert_dc_flat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd2) && $past(in_valid, 2) &&
         ($past(in_vec[LANES*SW-1:SW], 2) == '0))
        |-> (out_vec == {LANES{out_vec[SW-1:0]}}))
        else $error("R3: lane-0-only input gave unequal lanes");

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd1) && !out_valid) |-> $stable(out_vec))
        else $error("R8: output changed without valid");

endmodule

bind idct8_core idct8_core_chk #(.SW(SW), .LANES(idct8_pkg::LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_vec    (in_vec),
    .out_valid (out_valid),
    .out_vec   (out_vec)
);

// File: tb/idct8_core_tb.sv
module idct8_core_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_pass = 1'b0;
    logic [W-1:0] in_vec = '0;
    logic         out_valid;
    logic [W-1:0] out_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit mon_on = 1'b0;

    logic [1:0]   vpipe = '0;
    logic [W-1:0] last_out = '0;
    logic [W-1:0] exp_q [$];
    string        tag_q [$];

    idct8_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_pass   (in_pass),
        .in_vec    (in_vec),
        .out_valid (out_valid),
        .out_vec   (out_vec)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [W-1:0] ref_idct(input logic [W-1:0] v, input logic p);
        longint x [8];
        longint s [8];
        longint a, b, t2, t3, e0, e1, e2, e3, u, w, zu, zv, o0, o1, o2, o3, r;
        int sh;
        logic [W-1:0] res;
        for (int k = 0; k < 8; k++) x[k] = longint'($signed(v[16*k +: 16]));
        a  = (x[0] + x[4]) * 8192;
        b  = (x[0] - x[4]) * 8192;
        t2 = x[2] * 4433 + x[6] * (4433 - 15137);
        t3 = x[2] * (4433 + 6270) + x[6] * 4433;
        e0 = a + t3; e1 = b + t2; e2 = b - t2; e3 = a - t3;
        u  = x[7] + x[3];
        w  = x[5] + x[1];
        zu = u * (9633 - 16069) + w * 9633;
        zv = u * 9633 + w * (9633 - 3196);
        o0 = x[7] * (2446 - 7373) - x[1] * 7373 + zu;
        o1 = x[5] * (16819 - 20995) - x[3] * 20995 + zv;
        o2 = -x[5] * 20995 + x[3] * (25172 - 20995) + zu;
        o3 = -x[7] * 7373 + x[1] * (12299 - 7373) + zv;
        s[0] = e0 + o3; s[7] = e0 - o3;
        s[1] = e1 + o2; s[6] = e1 - o2;
        s[2] = e2 + o1; s[5] = e2 - o1;
        s[3] = e3 + o0; s[4] = e3 - o0;
        sh = p ? 18 : 11;
        for (int k = 0; k < 8; k++) begin
            r = (s[k] + (longint'(1) <<< (sh - 1))) >>> sh;
            if (r > 32767) r = 32767;
            if (r < -32768) r = -32768;
            res[16*k +: 16] = 16'(r);
        end
        return res;
    endfunction

    function automatic logic [W-1:0] one_lane(input int k, input int val);
        logic [W-1:0] r = '0;
        r[16*k +: 16] = 16'(val);
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic send(input logic [W-1:0] v, input logic p, input logic [W-1:0] exp,
                        input string tag);
        in_valid = 1'b1;
        in_pass  = p;
        in_vec   = v;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic gap();
        in_valid = 1'b0;
        in_vec   = '1;
        @(negedge clk);
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= {vpipe[0], in_valid};
    end

    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            check(out_valid == vpipe[1], "R2 out_valid timing",
                  W'(out_valid), W'(vpipe[1]));
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected result", out_vec, '0);
                end else begin
                    logic [W-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_vec == e, t, out_vec, e);
                end
            end else begin
                check(out_vec == last_out, "R8 hold while idle", out_vec, last_out);
            end
            last_out = out_vec;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog expired", '0, '1);
        finish_run();
    end

    localparam int NV = 14;
    int vals [NV] = '{-32768, -32767, -20000, -4097, -256, -17, -1,
                      1, 16, 255, 4096, 8191, 20000, 32767};
    int ext  [4]  = '{32767, -32767, -32768, 0};

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_vec == '0, "R1 reset state", out_vec, '0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_vec == '0, "R1 after release", out_vec, '0);

        // R5: rounding boundaries, second-pass shift, lane 0 only
        send(one_lane(0, 16),  1'b1, {8{16'sd1}},  "R5 round x=16");
        send(one_lane(0, 15),  1'b1, {8{16'sd0}},  "R5 round x=15");
        send(one_lane(0, -16), 1'b1, {8{16'sd0}},  "R5 round x=-16");
        send(one_lane(0, -17), 1'b1, {8{-16'sd1}}, "R5 round x=-17");
        send(one_lane(0, 47),  1'b1, {8{16'sd1}},  "R5 round x=47");
        send(one_lane(0, 48),  1'b1, {8{16'sd2}},  "R5 round x=48");
        send(one_lane(0, 1),   1'b0, {8{16'sd4}},  "R5 first pass x=1");
        // R6: clamp on the first pass
        send(one_lane(0, 8191),  1'b0, {8{16'sd32764}},  "R6 below limit");
        send(one_lane(0, 8192),  1'b0, {8{16'sh7fff}},   "R6 clamp high");
        send(one_lane(0, -8192), 1'b0, {8{16'sh8000}},   "R6 exact low");
        send(one_lane(0, -8193), 1'b0, {8{16'sh8000}},   "R6 clamp low");
        send(one_lane(0, 32767), 1'b0, {8{16'sh7fff}},   "R6 clamp max");
        gap();
        gap();

        // sweep: one nonzero lane, every lane, both passes
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 8; k++) begin
                for (int i = 0; i < NV; i++) begin
                    logic [W-1:0] v;
                    v = one_lane(k, vals[i]);
                    send(v, p[0], ref_idct(v, p[0]), (k % 2 == 0) ? "R3 even lane" : "R4 odd lane");
                end
            end
        end
        gap();

        // R9: distinct value per lane fixes lane order
        begin
            logic [W-1:0] v;
            for (int k = 0; k < 8; k++) v[16*k +: 16] = 16'(1000 * (k + 1) - 4000);
            send(v, 1'b1, ref_idct(v, 1'b1), "R9 lane order");
            send(v, 1'b0, ref_idct(v, 1'b0), "R9 lane order");
        end

        // R6 extremes: every lane from the extreme set
        for (int i = 0; i < 256; i++) begin
            logic [W-1:0] v;
            for (int k = 0; k < 8; k++) v[16*k +: 16] = 16'(ext[$urandom_range(0, 3)]);
            send(v, i[0], ref_idct(v, i[0]), "R6 extreme inputs");
        end

        // R7: random vectors, alternating passes, random idle gaps
        for (int i = 0; i < 1500; i++) begin
            logic [W-1:0] v;
            logic p;
            for (int k = 0; k < 8; k++) v[16*k +: 16] = 16'($urandom);
            p = 1'($urandom);
            if ($urandom_range(0, 4) == 0) gap();
            send(v, p, ref_idct(v, p), "R7 mixed passes");
        end

        repeat (4) gap();
        check(exp_q.size() == 0, "R2 results outstanding", W'(exp_q.size()), '0);
        finish_run();
    end

endmodule